// File: doc/BRIEF.md
# Software Flow Control Unit for One Serial Channel

This block handles in-band (software) flow control for a single serial channel. On the receive side it compares every incoming character against two programmable patterns, one meaning "resume" (Xon) and one meaning "stop" (Xoff). Each detection is recorded in a sticky status field that is cleared when the status byte is read. When flow control is enabled, a received Xoff halts the transmitter and a received Xon restarts it, and both characters are removed from the receive stream.

On the transmit side, the receive-FIFO level logic outside this block may ask for an Xon or an Xoff to be sent. The unit does this only while the automatic receiver flow mode is on. It holds the request as pending and puts the character into the shifter at the next character boundary, ahead of any queued FIFO data. It never cuts into a character that is already being shifted out. The serial shifter and the FIFOs sit outside this block. The shifter signals a boundary with `sh_ready`, and a bit-time strobe `bit_tick` sets the pacing after an injected character.

The status byte holds four 2-bit fields. Received flow characters are in [7:6]. The last automatically sent character is in [5:4]. The transmitter flow state is in [3:2]. The transmitter character type is in [1:0].

The flow state machine has four states:
- FL_NORMAL (00)
- FL_HALT_PEND (01)
- FL_RESUMED (10)
- FL_HALTED (11)

Its transitions are:
- FL_NORMAL goes to FL_HALT_PEND on an Xoff while the shifter is busy, or to FL_HALTED on an Xoff while the shifter is at a boundary.
- FL_HALT_PEND goes to FL_HALTED when `sh_ready` is seen, or back to FL_NORMAL on an Xon.
- FL_HALTED goes to FL_RESUMED on an Xon.
- FL_RESUMED goes to FL_NORMAL on a status read, or back to a halt state on an Xoff.
- Clearing `flow_en` forces FL_NORMAL from any state.

The character state machine has four states:
- CH_DATA (00)
- CH_WAIT (01)
- CH_XOFF_PEND (10)
- CH_XON_PEND (11)

Its transitions are:
- A request from any state goes to the matching pending state. If both requests arrive together, the Xoff request wins.
- A pending state goes to CH_WAIT when its character is loaded.
- CH_WAIT goes to CH_DATA on `bit_tick` while the FIFO holds data.
- Clearing `auto_en` drops a pending state to CH_DATA.

Top module: `xonxoff_flow`

## Requirements
- R1: status[7:6] records received flow characters, with bit 6 for Xoff and bit 7 for Xon (00 none, 01 Xoff, 10 Xon, 11 both). The field appears one cycle after the matching `rx_valid` and holds until a status read.
- R2: The received-character field updates on every matching character, even when `flow_en` and `auto_en` are both low.
- R3: A cycle with `stat_rd` high returns the current status and then clears status[7:6]. A detection in the same cycle as the read is kept in the field after the read.
- R4: status[5:4] shows the last automatically sent character (01 Xon, 10 Xoff) and never shows 11. It reads 00 while `auto_en` is low and is reset to 00 when `auto_en` is cleared.
- R5: status[3:2] follows the flow state machine above: 00 normal, 01 halt pending, 11 halted, and 10 re-enabled, which returns to 00 on a status read. No FIFO data is loaded in the halt-pending or halted states, or in a cycle in which an Xoff is received.
- R6: A pending Xon or Xoff is loaded only when `sh_ready` is high. It takes priority over FIFO data, so `fifo_pop` stays low in that cycle, and `sh_data` carries the flow character.
- R7: status[1:0] shows the character state: 00 data, 01 wait, 10 Xoff pending, 11 Xon pending. After an injection the wait state blocks data loads until a `bit_tick` arrives while the FIFO is non-empty.
- R8: While `flow_en` is high, received Xon and Xoff characters do not appear on `rx_out_valid`. While `flow_en` is low, every received character passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flow_en | input | 1 | Received Xon/Xoff control the transmitter and are stripped |
| auto_en | input | 1 | Automatic receiver flow mode (injection) enable |
| xon_char | input | 8 | Resume character pattern |
| xoff_char | input | 8 | Stop character pattern |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| rx_out_valid | output | 1 | Character forwarded to the receive FIFO |
| rx_out_data | output | 8 | Forwarded character |
| req_xon | input | 1 | Request to send Xon |
| req_xoff | input | 1 | Request to send Xoff |
| fifo_empty | input | 1 | Transmit FIFO has no data |
| fifo_data | input | 8 | Head of transmit FIFO |
| fifo_pop | output | 1 | Take head of transmit FIFO |
| sh_ready | input | 1 | Shifter at a character boundary |
| bit_tick | input | 1 | One-bit-time strobe |
| sh_load | output | 1 | Load `sh_data` into the shifter |
| sh_data | output | 8 | Character to shift out |
| stat_rd | input | 1 | Status read strobe |
| status | output | 8 | Status byte |

## Verification
The assertions assume that `xon_char` and `xoff_char` differ and stay constant while traffic flows. They also assume that `sh_ready` honestly reports a boundary, so a load while it is low would cut into a character. The stimulus sets the two patterns once, to distinct values, before any traffic. It changes the enables only between transactions, and it drives `sh_ready` directly to place each load on a chosen cycle. The sweep covers every receive character value with flow control both off and on.

// File: rtl/xfc_pkg.sv
package xfc_pkg;
    typedef enum logic [1:0] {
        FL_NORMAL    = 2'b00,
        FL_HALT_PEND = 2'b01,
        FL_RESUMED   = 2'b10,
        FL_HALTED    = 2'b11
    } flow_st_e;

    typedef enum logic [1:0] {
        CH_DATA      = 2'b00,
        CH_WAIT      = 2'b01,
        CH_XOFF_PEND = 2'b10,
        CH_XON_PEND  = 2'b11
    } chr_st_e;

    localparam logic [1:0] AUTO_NONE = 2'b00;
    localparam logic [1:0] AUTO_XON  = 2'b01;
    localparam logic [1:0] AUTO_XOFF = 2'b10;
endpackage

// File: rtl/xfc_rx_match.sv
module xfc_rx_match #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flow_en,
    input  logic         stat_rd,
    input  logic [W-1:0] xon_char,
    input  logic [W-1:0] xoff_char,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    output logic         rx_out_valid,
    output logic [W-1:0] rx_out_data,
    output logic         hit_xon,
    output logic         hit_xoff,
    output logic [1:0]   rx_field
);
    logic is_xon, is_xoff;
    logic [1:0] field_q;

    assign is_xon  = rx_valid && (rx_data == xon_char);
    assign is_xoff = rx_valid && (rx_data == xoff_char);

    // Flow characters are consumed only while flow control is active
    assign hit_xon      = is_xon  && flow_en;
    assign hit_xoff     = is_xoff && flow_en;
    assign rx_out_valid = rx_valid && !(hit_xon || hit_xoff);
    assign rx_out_data  = rx_data;

    // Sticky detector: read clears first, a same-cycle detection is ORed back in
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            field_q <= 2'b00;
        else
            field_q <= (stat_rd ? 2'b00 : field_q) | {is_xon, is_xoff};
    end

    assign rx_field = field_q;
endmodule

// File: rtl/xfc_flow_fsm.sv
module xfc_flow_fsm
    import xfc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     flow_en,
    input  logic     hit_xon,
    input  logic     hit_xoff,
    input  logic     sh_ready,
    input  logic     stat_rd,
    output flow_st_e flow_st,
    output logic     tx_allow
);
    flow_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= FL_NORMAL;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FL_NORMAL: begin
                if (hit_xoff)
                    st_d = sh_ready ? FL_HALTED : FL_HALT_PEND;
            end
            FL_HALT_PEND: begin
                if (hit_xon && !hit_xoff)
                    st_d = FL_NORMAL;
                else if (sh_ready)
                    st_d = FL_HALTED;
            end
            FL_HALTED: begin
                if (hit_xon && !hit_xoff)
                    st_d = FL_RESUMED;
            end
            FL_RESUMED: begin
                if (hit_xoff)
                    st_d = sh_ready ? FL_HALTED : FL_HALT_PEND;
                else if (stat_rd)
                    st_d = FL_NORMAL;
            end
        endcase
        if (!flow_en)
            st_d = FL_NORMAL;
    end

    assign flow_st  = st_q;
    assign tx_allow = ((st_q == FL_NORMAL) || (st_q == FL_RESUMED)) && !hit_xoff;
endmodule

// File: rtl/xfc_inject.sv
module xfc_inject
    import xfc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         auto_en,
    input  logic         req_xon,
    input  logic         req_xoff,
    input  logic         sh_ready,
    input  logic         bit_tick,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_data,
    input  logic         tx_allow,
    input  logic [W-1:0] xon_char,
    input  logic [W-1:0] xoff_char,
    output logic         sh_load,
    output logic [W-1:0] sh_data,
    output logic         fifo_pop,
    output chr_st_e      chr_st,
    output logic [1:0]   auto_field
);
    chr_st_e    st_q, st_d;
    logic [1:0] auto_q;
    logic       pending, load_flow, load_data;

    assign pending   = (st_q == CH_XOFF_PEND) || (st_q == CH_XON_PEND);
    assign load_flow = pending && auto_en && sh_ready;
    assign load_data = (st_q == CH_DATA) && sh_ready && tx_allow && !fifo_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= CH_DATA;
            auto_q <= AUTO_NONE;
        end else begin
            st_q <= st_d;
            if (!auto_en)
                auto_q <= AUTO_NONE;
            else if (load_flow)
                auto_q <= (st_q == CH_XON_PEND) ? AUTO_XON : AUTO_XOFF;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_DATA: st_d = CH_DATA;
            CH_WAIT: begin
                if (bit_tick && !fifo_empty)
                    st_d = CH_DATA;
            end
            CH_XOFF_PEND, CH_XON_PEND: begin
                if (load_flow)
                    st_d = CH_WAIT;
                else if (!auto_en)
                    st_d = CH_DATA;
            end
        endcase
        if (auto_en && req_xoff)
            st_d = CH_XOFF_PEND;
        else if (auto_en && req_xon)
            st_d = CH_XON_PEND;
    end

    assign sh_load    = load_flow || load_data;
    assign fifo_pop   = load_data;
    assign sh_data    = !load_flow ? fifo_data :
                        (st_q == CH_XON_PEND) ? xon_char : xoff_char;
    assign chr_st     = st_q;
    assign auto_field = auto_en ? auto_q : AUTO_NONE;
endmodule

// File: rtl/xonxoff_flow.sv
module xonxoff_flow
    import xfc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flow_en,
    input  logic         auto_en,
    input  logic [W-1:0] xon_char,
    input  logic [W-1:0] xoff_char,
    input  logic         rx_valid,
    input  logic [W-1:0] rx_data,
    output logic         rx_out_valid,
    output logic [W-1:0] rx_out_data,
    input  logic         req_xon,
    input  logic         req_xoff,
    input  logic         fifo_empty,
    input  logic [W-1:0] fifo_data,
    output logic         fifo_pop,
    input  logic         sh_ready,
    input  logic         bit_tick,
    output logic         sh_load,
    output logic [W-1:0] sh_data,
    input  logic         stat_rd,
    output logic [7:0]   status
);
    logic       hit_xon, hit_xoff, tx_allow;
    logic [1:0] rx_field, auto_field;
    flow_st_e   flow_st;
    chr_st_e    chr_st;

    xfc_rx_match #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .stat_rd(stat_rd),
        .xon_char(xon_char), .xoff_char(xoff_char),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
        .hit_xon(hit_xon), .hit_xoff(hit_xoff), .rx_field(rx_field)
    );

    xfc_flow_fsm u_flow (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en),
        .hit_xon(hit_xon), .hit_xoff(hit_xoff), .sh_ready(sh_ready),
        .stat_rd(stat_rd), .flow_st(flow_st), .tx_allow(tx_allow)
    );

    xfc_inject #(.W(W)) u_inj (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en),
        .req_xon(req_xon), .req_xoff(req_xoff), .sh_ready(sh_ready),
        .bit_tick(bit_tick), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
        .tx_allow(tx_allow), .xon_char(xon_char), .xoff_char(xoff_char),
        .sh_load(sh_load), .sh_data(sh_data), .fifo_pop(fifo_pop),
        .chr_st(chr_st), .auto_field(auto_field)
    );

    assign status = {rx_field, auto_field, flow_st, chr_st};
endmodule

// File: rtl/xfc_checker.sv
module xfc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         flow_en,
    input logic         auto_en,
    input logic [W-1:0] xon_char,
    input logic [W-1:0] xoff_char,
    input logic         rx_valid,
    input logic [W-1:0] rx_data,
    input logic         rx_out_valid,
    input logic         fifo_pop,
    input logic         sh_ready,
    input logic         sh_load,
    input logic [7:0]   status
);
    // R4: field forced to none while the mode is off, and 11 never shown
    a_r4_auto_off: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_en |-> status[5:4] == 2'b00);
    a_r4_no_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        status[5:4] != 2'b11);

    // R6: never load into a busy shifter; pending flow char beats FIFO data
    a_r6_boundary_only: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |-> sh_ready);
    a_r6_flow_first: assert property (@(posedge clk) disable iff (!rst_n)
        (status[1] && auto_en && sh_ready) |-> (sh_load && !fifo_pop));

    // R5: halted or halt pending means no data leaves the FIFO
    a_r5_halt_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3:2] == 2'b11 || status[3:2] == 2'b01) |-> !fifo_pop);

    // R3: a detection is never lost, even across a read
    a_r3_detect_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_data == xoff_char) |=> status[6]);

    // R8: flow characters are stripped while flow control is on
    a_r8_strip: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && rx_valid && (rx_data == xon_char || rx_data == xoff_char))
            |-> !rx_out_valid);
endmodule

bind xonxoff_flow xfc_checker #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .auto_en(auto_en),
    .xon_char(xon_char), .xoff_char(xoff_char),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_out_valid(rx_out_valid),
    .fifo_pop(fifo_pop), .sh_ready(sh_ready), .sh_load(sh_load),
    .status(status)
);

// File: tb/sim_xonxoff_flow.sv
module sim_xonxoff_flow;
    localparam logic [7:0] XON  = 8'h11;
    localparam logic [7:0] XOFF = 8'h13;
    localparam logic [7:0] DAT  = 8'hA5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flow_en = 1'b0, auto_en = 1'b0;
    logic       rx_valid = 1'b0, req_xon = 1'b0, req_xoff = 1'b0;
    logic [7:0] rx_data = 8'h00, fifo_data = DAT;
    logic       fifo_empty = 1'b0, sh_ready = 1'b0, bit_tick = 1'b0, stat_rd = 1'b0;
    logic       rx_out_valid, fifo_pop, sh_load;
    logic [7:0] rx_out_data, sh_data, status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xonxoff_flow u0 (
        .clk(clk), .rst_n(rst_n), .flow_en(flow_en), .auto_en(auto_en),
        .xon_char(XON), .xoff_char(XOFF),
        .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_out_valid(rx_out_valid), .rx_out_data(rx_out_data),
        .req_xon(req_xon), .req_xoff(req_xoff),
        .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .sh_ready(sh_ready), .bit_tick(bit_tick),
        .sh_load(sh_load), .sh_data(sh_data),
        .stat_rd(stat_rd), .status(status)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // one clock edge, returning to the falling edge for the next drive
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_clear();
        stat_rd = 1'b1;
        step();
        stat_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("reset status", status, 8'h00);
        chk("reset sh_load", sh_load, 1'b0);
        @(negedge clk);

        // R1 R2 R8: sweep every character value with flow control off then on
        for (int f = 0; f < 2; f++) begin
            flow_en = f[0];
            for (int d = 0; d < 256; d++) begin
                rx_valid = 1'b1;
                rx_data  = d[7:0];
                #1;
                chk(f == 0 ? "R8 pass-through" : "R8 strip", rx_out_valid,
                    !(f == 1 && (d == XON || d == XOXX(d))));
                step();
                rx_valid = 1'b0;
                stat_rd  = 1'b1;
                #1;
                chk(f == 0 ? "R2 detect enables off" : "R1 detect field",
                    status[7:6], {d[7:0] == XON, d[7:0] == XOFF});
                step();
                stat_rd = 1'b0;
            end
        end
        flow_en = 1'b0;
        step();
        chk("R1 cleared after read", status[7:6], 2'b00);

        // R1: both characters without a read in between
        rx_valid = 1'b1; rx_data = XOFF; step();
        rx_data = XON; step();
        rx_valid = 1'b0;
        chk("R1 both seen", status[7:6], 2'b11);
        read_clear();

        // R3: detection in the read cycle survives the clear
        rx_valid = 1'b1; rx_data = XOFF; step();
        rx_data = XON; stat_rd = 1'b1;
        #1;
        chk("R3 read returns old", status[7:6], 2'b01);
        step();
        rx_valid = 1'b0; stat_rd = 1'b0;
        chk("R3 detect wins", status[7:6], 2'b10);
        read_clear();
        chk("R3 cleared", status[7:6], 2'b00);

        // R4 R6 R7: injection
        req_xoff = 1'b1; step(); req_xoff = 1'b0;
        chk("R4 mode off no request", status[1:0], 2'b00);
        chk("R4 mode off field", status[5:4], 2'b00);
        auto_en = 1'b1;
        req_xoff = 1'b1; step(); req_xoff = 1'b0;
        chk("R7 xoff pending", status[1:0], 2'b10);
        #1;
        chk("R6 no load while busy", sh_load, 1'b0);
        sh_ready = 1'b1;
        #1;
        chk("R6 load at boundary", sh_load, 1'b1);
        chk("R6 xoff data", sh_data, XOFF);
        chk("R6 fifo held back", fifo_pop, 1'b0);
        step();
        chk("R7 wait after send", status[1:0], 2'b01);
        chk("R4 xoff sent", status[5:4], 2'b10);
        chk("R7 no data in wait", sh_load, 1'b0);
        step();
        chk("R7 wait holds without tick", status[1:0], 2'b01);
        bit_tick = 1'b1; step(); bit_tick = 1'b0;
        chk("R7 data after tick", status[1:0], 2'b00);
        #1;
        chk("R6 data load", {sh_load, fifo_pop}, 2'b11);
        chk("R6 data value", sh_data, DAT);
        req_xon = 1'b1; step(); req_xon = 1'b0;
        chk("R7 xon pending", status[1:0], 2'b11);
        #1;
        chk("R6 xon data", sh_data, XON);
        chk("R6 xon beats fifo", fifo_pop, 1'b0);
        step();
        chk("R4 xon sent", status[5:4], 2'b01);
        fifo_empty = 1'b1; bit_tick = 1'b1; step();
        chk("R7 wait holds when fifo empty", status[1:0], 2'b01);
        fifo_empty = 1'b0; step(); bit_tick = 1'b0;
        chk("R7 leaves wait", status[1:0], 2'b00);
        auto_en = 1'b0; step();
        chk("R4 reset on mode clear", status[5:4], 2'b00);

        // R5: flow state machine
        sh_ready = 1'b0; flow_en = 1'b1;
        rx_valid = 1'b1; rx_data = XOFF; step(); rx_valid = 1'b0;
        chk("R5 halt pending", status[3:2], 2'b01);
        sh_ready = 1'b1;
        #1;
        chk("R5 no load halt pending", sh_load, 1'b0);
        step();
        chk("R5 halted", status[3:2], 2'b11);
        chk("R5 no load halted", {sh_load, fifo_pop}, 2'b00);
        rx_valid = 1'b1; rx_data = XON; step(); rx_valid = 1'b0;
        chk("R5 re-enabled", status[3:2], 2'b10);
        #1;
        chk("R5 data resumes", sh_load, 1'b1);
        read_clear();
        chk("R5 normal after read", status[3:2], 2'b00);
        rx_valid = 1'b1; rx_data = XOFF;
        #1;
        chk("R5 no load on xoff cycle", sh_load, 1'b0);
        step(); rx_valid = 1'b0;
        chk("R5 direct halt at boundary", status[3:2], 2'b11);
        flow_en = 1'b0; step();
        chk("R5 forced normal", status[3:2], 2'b00);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic int XOXX(input int d);
        return (d == XOFF) ? d : -1;
    endfunction
endmodule